// File: doc/BRIEF.md
# Dual-Port Message Mailbox

This block lets two processors pass 32-bit messages to each other. It holds eight channels. Each channel is a four-deep first-in first-out queue that carries words in one direction at a time. Two users, A and B, each have a plain register port made of address, write strobe, write data, read strobe and read data. Both users see the same address map. The only difference is that "local" and "remote" swap meanings depending on which user is asking.

A sender writes a channel's data word to push a message. The receiver reads the same word to pop the oldest message. Each user has its own interrupt enable word, its own sticky interrupt status word and one level-high interrupt line. The receive flag of a channel cannot be cleared while that channel still holds data. A sender can read the receiver's status word through the remote window. When the receive flag drops, the sender knows that its message has been taken.

Top module: `dual_mailbox`

## Requirements
- R1: After reset every channel carries A→B, every queue is empty, and all enable, status and read-data registers are zero. From the first clock after reset, user A's local status reads 0x0000AAAA and user B's reads 0.
- R2: Control word k sits at byte address 4k and covers channels 4k..4k+3. For channel n, bit 8(n%4) reads 1 when the reading user receives on n, and bit 8(n%4)+4 reads 1 when it transmits on n. A write makes the writer the receiver of each covered channel whose bit 8(n%4) is 1, and the transmitter otherwise. If both users write the same control word in one cycle, B's write takes effect.
- R3: The data word of channel n is at 0x180+4n. A write by the channel's transmitter pushes a message, and a read by its receiver pops the oldest one. Messages come out in the order they were pushed. Read data is registered: it appears the cycle after the read strobe and holds until the next read.
- R4: The word at 0x140+4n returns the occupancy of channel n (0 to 4) in bits [2:0]. The word at 0x100+4n returns 1 in bit 0 when channel n is full.
- R5: The following accesses leave the queue unchanged: a push into a full queue, a push from the receiving user, and a pop from an empty queue or by the transmitting user. A pop that is ignored returns zero.
- R6: In the interrupt words, channel n's receive flag is bit 2n and its transmit flag is bit 2n+1. A user's own enable word is at 0x060 and its own status word at 0x070. 0x040 and 0x050 read the other user's enable and status words.
- R7: A user's receive flag for channel n sets when a message is pushed into a channel it receives on. Writing 1 to that bit at 0x070 clears it only if the queue was empty before that clock edge. Otherwise the write has no effect.
- R8: A user's transmit flag for channel n sets on every clock where that user transmits on n and the queue is not full. Writing 1 to the bit clears it, but the clear only takes effect while the queue is full.
- R9: Each interrupt line is high exactly when some status bit of that user is set together with its enable bit.
- R10: Writes to 0x040 and 0x050 have no effect on either user's enable or status.
- R11: A push and a pop on the same channel in the same cycle both take effect: the oldest message is returned and the new one is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | 9 | User A byte address |
| a_wr | input | 1 | User A write strobe |
| a_wdata | input | 32 | User A write data |
| a_rd | input | 1 | User A read strobe |
| a_rdata | output | 32 | User A registered read data |
| a_irq | output | 1 | User A interrupt, level high |
| b_addr | input | 9 | User B byte address |
| b_wr | input | 1 | User B write strobe |
| b_wdata | input | 32 | User B write data |
| b_rd | input | 1 | User B read strobe |
| b_rdata | output | 32 | User B registered read data |
| b_irq | output | 1 | User B interrupt, level high |

## Verification
A wrong read pointer or occupancy count shows up the cycle after the next pop, as a message out of order or a nonzero word from an empty queue. The occupancy word shows the same fault at once. A flag that clears early or sets late shows up one cycle after the triggering edge, either in the local or remote status words or on the interrupt line. The bench checks both, every cycle and for both users. A random mix of pushes, pops, direction changes and clears is compared against a queue model, so a corrupted pointer or a stale flag surfaces within a few accesses.

// File: rtl/dual_mailbox.sv
`timescale 1ns/1ps
module dual_mailbox #(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic          a_wr,
  input  logic [DW-1:0] a_wdata,
  input  logic          a_rd,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic [AW-1:0] b_addr,
  input  logic          b_wr,
  input  logic [DW-1:0] b_wdata,
  input  logic          b_rd,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = $clog2(DEPTH);
  localparam int IW  = 2 * NCH;
  localparam int NCW = (NCH + 3) / 4;

  logic [AW-1:0] addr  [2];
  logic          wr    [2];
  logic          rd    [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [DW-1:0] rv    [2];

  assign addr[0]  = a_addr;
  assign addr[1]  = b_addr;
  assign wr[0]    = a_wr;
  assign wr[1]    = b_wr;
  assign rd[0]    = a_rd;
  assign rd[1]    = b_rd;
  assign wdata[0] = a_wdata;
  assign wdata[1] = b_wdata;
  assign a_rdata  = rdata[0];
  assign b_rdata  = rdata[1];

  logic [DW-1:0]  mem [NCH][DEPTH];
  logic [PW-1:0]  rp  [NCH];
  logic [CW-1:0]  cnt [NCH];
  logic [NCH-1:0] dir;
  logic [IW-1:0]  en  [2];
  logic [IW-1:0]  st  [2];
  logic [NCH-1:0] push, pop, full, empty;

  function automatic logic hit(logic [AW-1:0] a, int base, int idx);
    return a == AW'(base + 4 * idx);
  endfunction

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      full[n]  = cnt[n] == CW'(DEPTH);
      empty[n] = cnt[n] == '0;
      push[n]  = wr[dir[n]] && hit(addr[dir[n]], 'h180, n) && !full[n];
      pop[n]   = rd[~dir[n]] && hit(addr[~dir[n]], 'h180, n) && !empty[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) begin
        cnt[n] <= '0;
        rp[n]  <= '0;
      end
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (pop[n]) rp[n] <= rp[n] + PW'(1);
        cnt[n] <= cnt[n] + CW'(push[n]) - CW'(pop[n]);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int n = 0; n < NCH; n++)
      if (push[n]) mem[n][rp[n] + PW'(cnt[n])] <= wdata[dir[n]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '0;
      for (int u = 0; u < 2; u++) begin
        en[u] <= '0;
        st[u] <= '0;
      end
    end else begin
      for (int u = 0; u < 2; u++) begin
        for (int k = 0; k < NCW; k++)
          if (wr[u] && hit(addr[u], 0, k))
            for (int i = 0; i < 4; i++)
              if (4 * k + i < NCH)
                dir[4*k+i] <= wdata[u][8*i] ? ~1'(u) : 1'(u);
        if (wr[u] && hit(addr[u], 'h60, 0)) en[u] <= wdata[u][IW-1:0];
        for (int n = 0; n < NCH; n++) begin
          st[u][2*n]   <= (push[n] && dir[n] != 1'(u)) |
                          (st[u][2*n] & ~(wr[u] && hit(addr[u], 'h70, 0) &&
                                          wdata[u][2*n] && empty[n]));
          st[u][2*n+1] <= (dir[n] == 1'(u) && !full[n]) |
                          (st[u][2*n+1] & ~(wr[u] && hit(addr[u], 'h70, 0) &&
                                            wdata[u][2*n+1]));
        end
      end
    end
  end

  always_comb begin
    for (int u = 0; u < 2; u++) begin
      rv[u] = '0;
      for (int k = 0; k < NCW; k++)
        if (hit(addr[u], 0, k))
          for (int i = 0; i < 4; i++)
            if (4 * k + i < NCH) begin
              rv[u][8*i]   = dir[4*k+i] != 1'(u);
              rv[u][8*i+4] = dir[4*k+i] == 1'(u);
            end
      if (hit(addr[u], 'h40, 0)) rv[u][IW-1:0] = en[1-u];
      if (hit(addr[u], 'h50, 0)) rv[u][IW-1:0] = st[1-u];
      if (hit(addr[u], 'h60, 0)) rv[u][IW-1:0] = en[u];
      if (hit(addr[u], 'h70, 0)) rv[u][IW-1:0] = st[u];
      for (int n = 0; n < NCH; n++) begin
        if (hit(addr[u], 'h100, n)) rv[u][0] = full[n];
        if (hit(addr[u], 'h140, n)) rv[u][CW-1:0] = cnt[n];
        if (hit(addr[u], 'h180, n) && dir[n] != 1'(u) && !empty[n])
          rv[u] = mem[n][rp[n]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata[0] <= '0;
      rdata[1] <= '0;
    end else begin
      for (int u = 0; u < 2; u++)
        if (rd[u]) rdata[u] <= rv[u];
    end
  end

  assign a_irq = |(st[0] & en[0]);
  assign b_irq = |(st[1] & en[1]);

endmodule

// File: rtl/dual_mailbox_chk.sv
`timescale 1ns/1ps
module dual_mailbox_chk #(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_irq,
  input logic             b_irq,
  input logic [NCH-1:0]   dir,
  input logic [CW-1:0]    cnt [NCH],
  input logic [2*NCH-1:0] st_a,
  input logic [2*NCH-1:0] st_b,
  input logic [2*NCH-1:0] en_a,
  input logic [2*NCH-1:0] en_b
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[n] <= CW'(DEPTH));
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (int'(cnt[n]) - int'($past(cnt[n])) <= 1 &&
                   int'($past(cnt[n])) - int'(cnt[n]) <= 1));
    // R7
    rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(cnt[n]) == '0 && cnt[n] != '0 && $stable(dir[n])
      |-> (dir[n] ? st_a[2*n] : st_b[2*n]));
    // R8
    tx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(cnt[n] != CW'(DEPTH) && !dir[n]) |-> st_a[2*n+1]);
  end

  // R9
  irq_a_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_irq |-> (st_a != '0 && en_a != '0));
  // R9
  irq_b_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_irq |-> (st_b != '0 && en_b != '0));
endmodule

bind dual_mailbox dual_mailbox_chk #(.NCH(NCH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_irq(a_irq), .b_irq(b_irq), .dir(dir),
  .cnt(cnt), .st_a(st[0]), .st_b(st[1]), .en_a(en[0]), .en_b(en[1]));

// File: tb/dual_mailbox_test.sv
`timescale 1ns/1ps
module dual_mailbox_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [8:0]  a_addr = '0, b_addr = '0;
  logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  dual_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wr(a_wr), .a_wdata(a_wdata), .a_rd(a_rd),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_addr(b_addr), .b_wr(b_wr), .b_wdata(b_wdata), .b_rd(b_rd),
    .b_rdata(b_rdata), .b_irq(b_irq));

  int checks = 0, errors = 0;
  bit done = 0;

  bit [31:0] q [8][4];
  int        qh [8], qc [8];
  bit        mdir [8];
  bit [15:0] men [2], mst [2];

  task automatic chk(bit ok, string tg, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  function automatic bit [31:0] mread(bit u, bit [8:0] ad);
    bit [31:0] v = '0;
    for (int k = 0; k < 2; k++)
      if (ad == 9'(4 * k))
        for (int i = 0; i < 4; i++) begin
          v[8*i]   = mdir[4*k+i] != u;
          v[8*i+4] = mdir[4*k+i] == u;
        end
    if (ad == 9'h040) v = {16'h0, men[~u]};
    if (ad == 9'h050) v = {16'h0, mst[~u]};
    if (ad == 9'h060) v = {16'h0, men[u]};
    if (ad == 9'h070) v = {16'h0, mst[u]};
    for (int n = 0; n < 8; n++) begin
      if (ad == 9'(256 + 4 * n)) v = {31'h0, qc[n] == 4};
      if (ad == 9'(320 + 4 * n)) v = 32'(qc[n]);
      if (ad == 9'(384 + 4 * n) && mdir[n] != u && qc[n] > 0) v = q[n][qh[n]];
    end
    return v;
  endfunction

  task automatic step(bit aw, bit ar, bit [8:0] aa, bit [31:0] ad,
                      bit bw, bit br, bit [8:0] ba, bit [31:0] bd, string tg);
    bit [31:0] ea, eb;
    bit psh [8];
    bit pp [8];
    bit w [2];
    bit r [2];
    bit [8:0] ax [2];
    bit [31:0] dx [2];
    bit [15:0] nst [2];
    a_wr = aw; a_rd = ar; a_addr = aa; a_wdata = ad;
    b_wr = bw; b_rd = br; b_addr = ba; b_wdata = bd;
    w[0] = aw; w[1] = bw; r[0] = ar; r[1] = br;
    ax[0] = aa; ax[1] = ba; dx[0] = ad; dx[1] = bd;
    ea = mread(0, aa);
    eb = mread(1, ba);
    for (int n = 0; n < 8; n++) begin
      bit s = mdir[n];
      psh[n] = w[s] && ax[s] == 9'(384 + 4 * n) && qc[n] < 4;
      pp[n]  = r[~s] && ax[~s] == 9'(384 + 4 * n) && qc[n] > 0;
    end
    for (int u = 0; u < 2; u++) begin
      bit clr = w[u] && ax[u] == 9'h070;
      for (int n = 0; n < 8; n++) begin
        nst[u][2*n]   = (psh[n] && mdir[n] != 1'(u)) |
                        (mst[u][2*n] & ~(clr & dx[u][2*n] & (qc[n] == 0)));
        nst[u][2*n+1] = (mdir[n] == 1'(u) && qc[n] < 4) |
                        (mst[u][2*n+1] & ~(clr & dx[u][2*n+1]));
      end
    end
    for (int n = 0; n < 8; n++) begin
      if (psh[n]) q[n][(qh[n] + qc[n]) % 4] = dx[mdir[n]];
      if (pp[n]) qh[n] = (qh[n] + 1) % 4;
      qc[n] = qc[n] + int'(psh[n]) - int'(pp[n]);
    end
    for (int u = 0; u < 2; u++) begin
      if (w[u] && ax[u] == 9'h060) men[u] = dx[u][15:0];
      for (int k = 0; k < 2; k++)
        if (w[u] && ax[u] == 9'(4 * k))
          for (int i = 0; i < 4; i++)
            mdir[4*k+i] = dx[u][8*i] ? ~1'(u) : 1'(u);
    end
    mst = nst;
    @(negedge clk);
    if (ar) chk(a_rdata == ea, {tg, " A read"}, a_rdata, ea);
    if (br) chk(b_rdata == eb, {tg, " B read"}, b_rdata, eb);
    chk(a_irq == |(mst[0] & men[0]), {tg, " R9 A irq"}, 32'(a_irq), 32'(|(mst[0] & men[0])));
    chk(b_irq == |(mst[1] & men[1]), {tg, " R9 B irq"}, 32'(b_irq), 32'(|(mst[1] & men[1])));
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
  endtask

  task automatic idle(string tg);
    step(0, 0, 0, 0, 0, 0, 0, 0, tg);
  endtask
  task automatic aw_(bit [8:0] ad, bit [31:0] d, string tg);
    step(1, 0, ad, d, 0, 0, 0, 0, tg);
  endtask
  task automatic bw_(bit [8:0] ad, bit [31:0] d, string tg);
    step(0, 0, 0, 0, 1, 0, ad, d, tg);
  endtask
  task automatic ar_(bit [8:0] ad, string tg);
    step(0, 1, ad, 0, 0, 0, 0, 0, tg);
  endtask
  task automatic br_(bit [8:0] ad, string tg);
    step(0, 0, 0, 0, 0, 1, ad, 0, tg);
  endtask

  function automatic bit [8:0] raddr(int kind, int n);
    case (kind)
      0, 1, 2: return 9'(384 + 4 * n);
      3:       return 9'(320 + 4 * n);
      4:       return 9'(256 + 4 * n);
      5:       return 9'(4 * (n % 2));
      6:       return 9'h060;
      7:       return 9'h070;
      8:       return 9'h040;
      default: return 9'h050;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    for (int n = 0; n < 8; n++) begin qh[n] = 0; qc[n] = 0; mdir[n] = 0; end
    men[0] = 0; men[1] = 0; mst[0] = 0; mst[1] = 0;
    repeat (3) @(negedge clk);
    chk(a_irq == 0 && b_irq == 0, "R1 irq in reset", 32'({a_irq, b_irq}), 0);
    chk(a_rdata == 0 && b_rdata == 0, "R1 rdata in reset", a_rdata | b_rdata, 0);
    rst_n = 1;

    // R1 reset directions and flags
    ar_(9'h000, "R1 ctrl");
    idle("R1");
    ar_(9'h070, "R1 A status");
    chk(a_rdata == 32'h0000AAAA, "R1 A status const", a_rdata, 32'h0000AAAA);
    br_(9'h070, "R1 B status");
    chk(b_rdata == 32'h0, "R1 B status const", b_rdata, 0);
    br_(9'h004, "R1 ctrl B");

    // R3 ordering
    for (int i = 0; i < 4; i++) aw_(9'h180, 32'hA000_0000 + i, "R3 push");
    br_(9'h140, "R4 count");
    for (int i = 0; i < 4; i++) br_(9'h180, "R3 pop");

    // R4 / R5 full and ignored accesses
    for (int i = 0; i < 5; i++) aw_(9'h188, 32'hB000_0000 + i, "R5 push full");
    ar_(9'h108, "R4 full");
    chk(a_rdata == 1, "R4 full const", a_rdata, 1);
    br_(9'h148, "R4 count");
    chk(b_rdata == 4, "R4 count const", b_rdata, 4);
    bw_(9'h188, 32'hDEAD_BEEF, "R5 receiver push");
    ar_(9'h188, "R5 sender pop");
    chk(a_rdata == 0, "R5 sender pop zero", a_rdata, 0);
    ar_(9'h148, "R5 count kept");
    for (int i = 0; i < 4; i++) br_(9'h188, "R5 order");
    br_(9'h188, "R5 empty pop");
    chk(b_rdata == 0, "R5 empty pop zero", b_rdata, 0);

    // R7 receive flag and remote view (R6)
    aw_(9'h18C, 32'h1234_5678, "R7 push");
    bw_(9'h070, 32'h40, "R7 clear nonempty");
    br_(9'h070, "R7 flag held");
    chk(b_rdata[6] == 1, "R7 flag held const", b_rdata, 32'h40);
    ar_(9'h050, "R6 remote status");
    br_(9'h18C, "R7 pop");
    bw_(9'h070, 32'h40, "R7 clear empty");
    br_(9'h070, "R7 flag cleared");
    chk(b_rdata[6] == 0, "R7 cleared const", b_rdata, 0);
    ar_(9'h050, "R6 remote cleared");

    // R8 transmit flag
    for (int i = 0; i < 4; i++) aw_(9'h190, 32'hC000_0000 + i, "R8 fill");
    aw_(9'h070, 32'h200, "R8 clear full");
    ar_(9'h070, "R8 cleared");
    chk(a_rdata[9] == 0, "R8 cleared const", a_rdata, 0);
    br_(9'h190, "R8 pop");
    idle("R8");
    ar_(9'h070, "R8 reset flag");
    chk(a_rdata[9] == 1, "R8 set const", a_rdata, 32'h200);
    for (int i = 0; i < 3; i++) br_(9'h190, "R8 drain");

    // R9 interrupt
    bw_(9'h060, 32'h400, "R9 enable");
    aw_(9'h194, 32'h5555_0001, "R9 push");
    chk(b_irq == 1, "R9 irq high", 32'(b_irq), 1);
    br_(9'h194, "R9 pop");
    bw_(9'h070, 32'h400, "R9 clear");
    chk(b_irq == 0, "R9 irq low", 32'(b_irq), 0);

    // R10 remote window read-only
    aw_(9'h040, 32'hFFFF, "R10 write remote en");
    aw_(9'h050, 32'hFFFF, "R10 write remote st");
    br_(9'h060, "R10 B enable");
    chk(b_rdata == 32'h400, "R10 enable const", b_rdata, 32'h400);
    br_(9'h070, "R10 B status");
    ar_(9'h060, "R10 A enable");

    // R2 direction control
    bw_(9'h000, 32'h0101_0001, "R2 set dir");
    ar_(9'h000, "R2 A ctrl");
    chk(a_rdata == 32'h1010_0110, "R2 ctrl const", a_rdata, 32'h1010_0110);
    bw_(9'h184, 32'h7777_0001, "R2 B push");
    aw_(9'h184, 32'h7777_0002, "R2 A push ignored");
    ar_(9'h184, "R2 A pop");
    step(1, 0, 9'h004, 32'h0, 1, 0, 9'h004, 32'h1, "R2 both write");
    ar_(9'h004, "R2 B wins");
    br_(9'h004, "R2 B view");
    aw_(9'h004, 32'h0, "R2 restore");

    // R11 simultaneous push and pop
    aw_(9'h180, 32'hE000_0001, "R11 push");
    step(1, 0, 9'h180, 32'hE000_0002, 0, 1, 9'h180, 0, "R11 push+pop");
    chk(b_rdata == 32'hE000_0001, "R11 first const", b_rdata, 32'hE000_0001);
    br_(9'h140, "R11 count");
    br_(9'h180, "R11 second");

    // random mix (R3 R5 R7 R8)
    for (int it = 0; it < 3000; it++) begin
      bit [1:0] opa = 2'($urandom % 3), opb = 2'($urandom % 3);
      int ka = int'($urandom % 10), kb = int'($urandom % 10);
      int na = int'($urandom % 8), nb = int'($urandom % 8);
      if (ka == 5 && opa == 1 && ($urandom % 8) != 0) ka = 0;
      if (kb == 5 && opb == 1 && ($urandom % 8) != 0) kb = 0;
      step(opa == 1, opa == 2, raddr(ka, na), $urandom,
           opb == 1, opb == 2, raddr(kb, nb), $urandom, "random R3/R5/R7/R8");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule